// File: doc/BRIEF.md
# Battery Charge Switch Sequencer

This block decides, clock by clock, whether the charging switch between the charger input and the battery conducts. It takes raw digital comparator flags: charger voltage present, battery below and above the master-reset window, battery full, and an over/under pair for each selectable cut-off limit. It conditions these flags and runs a four-state machine. The states cover a start-up constant-current phase for a deeply discharged battery and a normal phase with a hysteretic cut-off.

In the normal phase the switch is driven by a PWM derived from a 32 kHz tick. The PWM period depends on whether a two-wire or a three-wire charger is fitted, and the on-time comes from a 5-bit duty code. A charger-present flag and a 2-bit mode code are provided for software. The analog comparators, current sensing and charger identification live elsewhere.

The states are IDLE, STARTUP, NORMAL_ON and CUTOFF. The transitions are:
- **IDLE→STARTUP**: charger rise while the battery is below the lower master-reset level.
- **IDLE→NORMAL_ON**: charger rise otherwise.
- **STARTUP→NORMAL_ON**: battery above the upper master-reset level.
- **NORMAL_ON→CUTOFF**: the selected limit's over flag.
- **CUTOFF→NORMAL_ON**: the selected limit's under flag.
- **any→IDLE**: charger lost.

Top module: `chg_seq_top`

## Requirements
- R1: Every raw flag passes through a two-flop synchronizer. The conditioned value then changes only after the synchronized value has differed from it on 4 consecutive 32 kHz ticks. A pulse seen on fewer than 4 ticks is ignored.
- R2: `chg_present` equals the conditioned charger flag. When that flag is low, the state goes to IDLE on the next clock and the switch is off.
- R3: A rising edge of the conditioned charger flag while the conditioned battery-below-master-reset flag is high enters STARTUP. In STARTUP, `sw_en` and `startup_cc` are 1 whatever the duty code.
- R4: STARTUP moves to NORMAL_ON when the conditioned battery-above-master-reset flag is high.
- R5: STARTUP is entered only from IDLE on a new charger rising edge. A battery that falls below the master-reset level in NORMAL_ON or CUTOFF does not return the block to STARTUP.
- R6: `lim_sel` picks the cut-off limit: 0 picks bit 0 (lowest, default), 1 picks bit 1, 2 picks bit 2, and 3 picks bit 0. NORMAL_ON goes to CUTOFF on the selected `lim_over` bit. CUTOFF goes back to NORMAL_ON on the selected `lim_under` bit. Unselected bits have no effect.
- R7: In CUTOFF and IDLE, `sw_en` is 0.
- R8: In NORMAL_ON, the PWM counter advances on each tick over a period of 32768 ticks when `chg_three_wire`=0, and 1024 ticks when it is 1. The switch is on while the count is below duty×period/32.
- R9: Duty code 0 keeps the switch off, and duty code 31 keeps it on for the whole period.
- R10: A conditioned battery-full flag forces `sw_en` to 0 in every state without changing the state.
- R11: `mode_status` encodes the state as IDLE=0, STARTUP=1, NORMAL_ON=2, CUTOFF=3.
- R12: After reset the block is in IDLE with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-clock pulse at the 32 kHz rate |
| chg_in_det | input | 1 | Charger input above detect threshold (raw) |
| bat_below_mrst | input | 1 | Battery below lower master-reset level (raw) |
| bat_above_mrst | input | 1 | Battery above upper master-reset level (raw) |
| bat_full | input | 1 | Battery reached full voltage (raw) |
| lim_over | input | 3 | Battery above upper level of each cut-off limit (raw) |
| lim_under | input | 3 | Battery below lower level of each cut-off limit (raw) |
| chg_three_wire | input | 1 | 1 = three-wire charger (short period), 0 = two-wire |
| duty_code | input | 5 | PWM duty, 0 off to 31 fully on |
| lim_sel | input | 2 | Cut-off limit select |
| sw_en | output | 1 | Charging switch enable |
| chg_present | output | 1 | Conditioned charger-present flag |
| startup_cc | output | 1 | Start-up constant-current request |
| mode_status | output | 2 | State code |

## Verification
On every cycle, the assertions check the following:
- The conditioned flags move only on a tick.
- A lost charger forces IDLE.
- STARTUP is entered only on a charger rise and never from the charging states.
- CUTOFF holds until its under flag.
- The PWM counter wraps at its period.
- Duty 0 and a full battery keep the switch off.

Only the bench scenarios can show the following:
- Short glitches and slow ticks are rejected.
- The on-time over whole 1024- and 32768-tick windows is correct.
- Each limit-select code steers the right flag pair, and unselected flags are ignored.
- Start-up restarts after the charger is removed and reconnected.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_STARTUP   = 2'd1,
        ST_NORMAL_ON = 2'd2,
        ST_CUTOFF    = 2'd3
    } chg_state_e;

    // positions of the fixed flags in the conditioned flag vector
    localparam int unsigned FL_CHG   = 0;
    localparam int unsigned FL_MLO   = 1;
    localparam int unsigned FL_MHI   = 2;
    localparam int unsigned FL_FULL  = 3;
    localparam int unsigned FL_FIXED = 4;

endpackage

// File: rtl/chg_flag_cond.sv
module chg_flag_cond #(
    parameter int unsigned DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    localparam int unsigned DCW = $clog2(DEB_TICKS) + 1;

    logic           sync1_q, sync2_q;
    logic [DCW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            run_q   <= '0;
            clean   <= 1'b0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            if (sync2_q == clean) begin
                run_q <= '0;
            end else if (tick) begin
                if (run_q == DCW'(DEB_TICKS - 1)) begin
                    clean <= sync2_q;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    // a conditioned flag may only move on a tick
    assert_tick_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> $past(tick))
        else $error("conditioned flag changed without a tick");

endmodule

// File: rtl/chg_pwm.sv
module chg_pwm #(
    parameter int unsigned DUTY_W = 5,
    parameter int unsigned PER_2W = 32768,
    parameter int unsigned PER_3W = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              three_wire,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_on
);
    localparam int unsigned PER_W  = $clog2(PER_2W) + 1;
    localparam int unsigned CNT_W  = PER_W - 1;
    localparam int unsigned PROD_W = PER_W + DUTY_W;
    localparam logic [PER_W-1:0] P2 = PER_W'(PER_2W);
    localparam logic [PER_W-1:0] P3 = PER_W'(PER_3W);

    logic [CNT_W-1:0]  cnt_q;
    logic [DUTY_W-1:0] duty_q;
    logic              type_q;
    logic [PER_W-1:0]  period;
    logic [PROD_W-1:0] thr;
    logic              at_end;

    always_comb begin
        period = type_q ? P3 : P2;
        at_end = PER_W'(cnt_q) >= (period - 1'b1);
        thr    = PROD_W'(duty_q) * PROD_W'(period >> DUTY_W);
        if (duty_q == '0) begin
            pwm_on = 1'b0;
        end else if (duty_q == '1) begin
            pwm_on = 1'b1;
        end else begin
            pwm_on = PROD_W'(cnt_q) < thr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
            type_q <= 1'b0;
        end else begin
            duty_q <= duty;
            type_q <= three_wire;
            if (tick) begin
                cnt_q <= at_end ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && PER_W'(cnt_q) == period - 1'b1) |=> cnt_q == '0)
        else $error("PWM counter did not wrap at its period");

    assert_duty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_on)
        else $error("PWM on with zero duty");

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
    import chg_seq_pkg::*;
#(
    parameter int unsigned NUM_LIMITS = 3,
    parameter int unsigned SEL_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vch,
    input  logic                  mlo,
    input  logic                  mhi,
    input  logic                  full,
    input  logic [NUM_LIMITS-1:0] over,
    input  logic [NUM_LIMITS-1:0] under,
    input  logic [SEL_W-1:0]      lim_sel,
    input  logic                  pwm_on,
    output logic                  sw_en,
    output logic                  startup_cc,
    output logic [1:0]            mode
);
    chg_state_e       state_q, state_d;
    logic             vch_d_q;
    logic             vch_rise;
    logic [SEL_W-1:0] idx;
    logic             over_sel, under_sel;

    always_comb begin
        idx = (32'(lim_sel) < NUM_LIMITS) ? lim_sel : '0;
        over_sel  = over[idx];
        under_sel = under[idx];
        vch_rise  = vch && !vch_d_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vch_d_q <= 1'b0;
        end else begin
            state_q <= state_d;
            vch_d_q <= vch;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!vch) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (vch_rise) state_d = mlo ? ST_STARTUP : ST_NORMAL_ON;
                end
                ST_STARTUP: begin
                    if (mhi) state_d = ST_NORMAL_ON;
                end
                ST_NORMAL_ON: begin
                    if (over_sel) state_d = ST_CUTOFF;
                end
                ST_CUTOFF: begin
                    if (under_sel) state_d = ST_NORMAL_ON;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mode       = state_q;
        startup_cc = 1'b0;
        sw_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:      sw_en = 1'b0;
            ST_STARTUP: begin
                startup_cc = 1'b1;
                sw_en      = !full;
            end
            ST_NORMAL_ON: sw_en = pwm_on && !full;
            ST_CUTOFF:    sw_en = 1'b0;
        endcase
    end

    assert_idle_on_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vch |=> state_q == ST_IDLE)
        else $error("charger lost but not idle");

    assert_startup_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_STARTUP) |-> $past(vch && !vch_d_q && mlo))
        else $error("start-up entered without charger rise");

    assert_no_reentry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL_ON || state_q == ST_CUTOFF) |=> state_q != ST_STARTUP)
        else $error("start-up re-entered from a charging state");

    assert_cutoff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CUTOFF && vch && !under_sel) |=> state_q == ST_CUTOFF)
        else $error("cut-off left without under flag");

    assert_full_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !sw_en)
        else $error("switch on with battery full");

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
    import chg_seq_pkg::*;
#(
    parameter int unsigned NUM_LIMITS = 3,
    parameter int unsigned DUTY_W     = 5,
    parameter int unsigned DEB_TICKS  = 4,
    parameter int unsigned PER_2W     = 32768,
    parameter int unsigned PER_3W     = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_32k,
    input  logic                  chg_in_det,
    input  logic                  bat_below_mrst,
    input  logic                  bat_above_mrst,
    input  logic                  bat_full,
    input  logic [NUM_LIMITS-1:0] lim_over,
    input  logic [NUM_LIMITS-1:0] lim_under,
    input  logic                  chg_three_wire,
    input  logic [DUTY_W-1:0]     duty_code,
    input  logic [$clog2(NUM_LIMITS)-1:0] lim_sel,
    output logic                  sw_en,
    output logic                  chg_present,
    output logic                  startup_cc,
    output logic [1:0]            mode_status
);
    localparam int unsigned NFLAG = FL_FIXED + 2 * NUM_LIMITS;
    localparam int unsigned SEL_W = $clog2(NUM_LIMITS);

    logic [NFLAG-1:0] raw_flags, cond_flags;
    logic             pwm_on;

    assign raw_flags = {lim_under, lim_over, bat_full, bat_above_mrst,
                        bat_below_mrst, chg_in_det};

    for (genvar g = 0; g < NFLAG; g++) begin : g_cond
        chg_flag_cond #(.DEB_TICKS(DEB_TICKS)) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_32k),
            .raw   (raw_flags[g]),
            .clean (cond_flags[g])
        );
    end

    chg_pwm #(.DUTY_W(DUTY_W), .PER_2W(PER_2W), .PER_3W(PER_3W)) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_32k),
        .three_wire (chg_three_wire),
        .duty       (duty_code),
        .pwm_on     (pwm_on)
    );

    chg_fsm #(.NUM_LIMITS(NUM_LIMITS), .SEL_W(SEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vch        (cond_flags[FL_CHG]),
        .mlo        (cond_flags[FL_MLO]),
        .mhi        (cond_flags[FL_MHI]),
        .full       (cond_flags[FL_FULL]),
        .over       (cond_flags[FL_FIXED +: NUM_LIMITS]),
        .under      (cond_flags[FL_FIXED + NUM_LIMITS +: NUM_LIMITS]),
        .lim_sel    (lim_sel),
        .pwm_on     (pwm_on),
        .sw_en      (sw_en),
        .startup_cc (startup_cc),
        .mode       (mode_status)
    );

    assign chg_present = cond_flags[FL_CHG];

    assert_present_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_present |=> mode_status == 2'd0 && !sw_en)
        else $error("no charger but block active");

endmodule

// File: tb/chg_seq_top_bench.sv
module chg_seq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       chg_in_det = 1'b0, bat_below_mrst = 1'b0, bat_above_mrst = 1'b0, bat_full = 1'b0;
    logic [2:0] lim_over = '0, lim_under = '0;
    logic       chg_three_wire = 1'b0;
    logic [4:0] duty_code = '0;
    logic [1:0] lim_sel = '0;
    logic       sw_en, chg_present, startup_cc;
    logic [1:0] mode_status;

    int checks = 0, fails = 0;
    int tick_div = 1;
    bit cmp_en = 0;
    string cur_req = "R12";

    always #4 clk = ~clk;

    chg_seq_top u_chg_seq_top (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
        .chg_in_det(chg_in_det), .bat_below_mrst(bat_below_mrst),
        .bat_above_mrst(bat_above_mrst), .bat_full(bat_full),
        .lim_over(lim_over), .lim_under(lim_under),
        .chg_three_wire(chg_three_wire), .duty_code(duty_code), .lim_sel(lim_sel),
        .sw_en(sw_en), .chg_present(chg_present), .startup_cc(startup_cc),
        .mode_status(mode_status)
    );

    // tick generator
    int tcount = 0;
    always begin
        @(negedge clk); #1;
        tcount++;
        tick_32k = (tcount % tick_div) == 0;
    end

    // ---------------- behavioural reference model ----------------
    bit s1[10], s2[10], cf[10];
    int run[10];
    bit vchd;
    int st;       // 0 idle 1 startup 2 normal 3 cutoff
    int pc, mduty, mtype;

    function automatic int per_of(int t);
        return t ? 1024 : 32768;
    endfunction

    function automatic bit pwm_model();
        if (mduty == 0) return 0;
        if (mduty == 31) return 1;
        return pc < mduty * (per_of(mtype) / 32);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 10; i++) begin s1[i] = 0; s2[i] = 0; cf[i] = 0; run[i] = 0; end
            vchd = 0; st = 0; pc = 0; mduty = 0; mtype = 0;
        end else begin
            bit raw[10];
            int sel, nst;
            raw[0] = chg_in_det; raw[1] = bat_below_mrst; raw[2] = bat_above_mrst; raw[3] = bat_full;
            for (int i = 0; i < 3; i++) begin raw[4+i] = lim_over[i]; raw[7+i] = lim_under[i]; end
            sel = (lim_sel == 3) ? 0 : int'(lim_sel);
            nst = st;
            if (!cf[0]) nst = 0;
            else if (st == 0) begin if (!vchd) nst = cf[1] ? 1 : 2; end
            else if (st == 1) begin if (cf[2]) nst = 2; end
            else if (st == 2) begin if (cf[4+sel]) nst = 3; end
            else begin if (cf[7+sel]) nst = 2; end
            st = nst;
            vchd = cf[0];
            if (tick_32k) pc = (pc >= per_of(mtype) - 1) ? 0 : pc + 1;
            mduty = int'(duty_code); mtype = int'(chg_three_wire);
            for (int i = 0; i < 10; i++) begin
                if (s2[i] == cf[i]) run[i] = 0;
                else if (tick_32k) begin
                    if (run[i] == 3) begin cf[i] = s2[i]; run[i] = 0; end
                    else run[i]++;
                end
                s2[i] = s1[i]; s1[i] = raw[i];
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle compare (R11 mode coding, R7, R10 as set by cur_req)
    always @(negedge clk) begin
        if (cmp_en) begin
            bit esw;
            esw = !cf[3] && (st == 1 || (st == 2 && pwm_model()));
            chk(cur_req, "mode_status", int'(mode_status), st);
            chk(cur_req, "chg_present", int'(chg_present), int'(cf[0]));
            chk(cur_req, "startup_cc", int'(startup_cc), int'(st == 1));
            chk(cur_req, "sw_en", int'(sw_en), int'(esw));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic count_on(int n, output int on);
        on = 0;
        repeat (n) begin @(negedge clk); if (sw_en) on++; end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int on;
        step(5);
        rst_n = 1'b1;
        step(1);
        // R12 reset state
        chk("R12", "mode", int'(mode_status), 0);
        chk("R12", "sw_en", int'(sw_en), 0);
        chk("R12", "present", int'(chg_present), 0);
        cmp_en = 1;

        // R1: three-tick glitch rejected
        cur_req = "R1";
        chg_in_det = 1; step(3); chg_in_det = 0; step(12);
        chk("R1", "glitch present", int'(chg_present), 0);
        // R1: slow ticks, 10 cycles is only a few ticks
        tick_div = 4; step(2);
        chg_in_det = 1; step(10); chg_in_det = 0; step(30);
        chk("R1", "slow-tick present", int'(chg_present), 0);
        tick_div = 1; step(4);

        // R3: start-up with battery deeply discharged, duty 0
        cur_req = "R3";
        bat_below_mrst = 1; step(10);
        chg_in_det = 1; step(15);
        chk("R3", "startup mode", int'(mode_status), 1);
        chk("R3", "startup sw", int'(sw_en), 1);
        chk("R2", "present", int'(chg_present), 1);

        // R10: full forces off, no state change
        cur_req = "R10";
        bat_full = 1; step(15);
        chk("R10", "full sw", int'(sw_en), 0);
        chk("R10", "full mode", int'(mode_status), 1);
        bat_full = 0; step(15);

        // R4: leave start-up above master reset
        cur_req = "R4";
        bat_below_mrst = 0; bat_above_mrst = 1; step(15);
        chk("R4", "normal mode", int'(mode_status), 2);
        chk("R9", "duty0 sw", int'(sw_en), 0);

        // R5: battery drops again, no return to start-up
        cur_req = "R5";
        bat_above_mrst = 0; bat_below_mrst = 1; step(20);
        chk("R5", "no reentry", int'(mode_status), 2);
        // R2: charger removed
        cur_req = "R2";
        chg_in_det = 0; step(15);
        chk("R2", "idle mode", int'(mode_status), 0);
        chk("R2", "idle present", int'(chg_present), 0);
        // R5: new rise restarts start-up
        cur_req = "R5";
        chg_in_det = 1; step(15);
        chk("R5", "restart", int'(mode_status), 1);
        bat_below_mrst = 0; bat_above_mrst = 1; step(15);
        chk("R4", "normal again", int'(mode_status), 2);

        // R6/R7: limit selection
        cur_req = "R6";
        duty_code = 31; lim_sel = 0; step(10);
        lim_over = 3'b010; step(15);
        chk("R6", "unselected over", int'(mode_status), 2);
        chk("R9", "duty31 sw", int'(sw_en), 1);
        lim_over = 3'b001; step(15);
        chk("R6", "sel0 cutoff", int'(mode_status), 3);
        chk("R7", "cutoff sw", int'(sw_en), 0);
        lim_over = 0; lim_under = 3'b010; step(15);
        chk("R6", "unselected under", int'(mode_status), 3);
        lim_under = 3'b001; step(15);
        chk("R6", "sel0 resume", int'(mode_status), 2);
        lim_under = 0; lim_sel = 2; lim_over = 3'b100; step(15);
        chk("R6", "sel2 cutoff", int'(mode_status), 3);
        lim_over = 0; lim_under = 3'b100; step(15);
        chk("R6", "sel2 resume", int'(mode_status), 2);
        lim_under = 0; lim_sel = 3; lim_over = 3'b001; step(15);
        chk("R6", "sel3 default cutoff", int'(mode_status), 3);
        lim_over = 0; lim_under = 3'b001; step(15);
        chk("R6", "sel3 resume", int'(mode_status), 2);
        lim_under = 0; step(10);

        // R8: three-wire period 1024, duty 8 -> 256 on
        cur_req = "R8";
        chg_three_wire = 1; duty_code = 8; step(50);
        count_on(1024, on);
        chk("R8", "3w on-count", on, 256);
        cur_req = "R9";
        duty_code = 31; step(10);
        count_on(1024, on);
        chk("R9", "3w duty31", on, 1024);
        duty_code = 0; step(10);
        count_on(1024, on);
        chk("R9", "3w duty0", on, 0);

        // R8: two-wire period 32768, duty 16 -> 16384 on
        cur_req = "R8";
        chg_three_wire = 0; duty_code = 16; step(50);
        count_on(32768, on);
        chk("R8", "2w on-count", on, 16384);

        cmp_en = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule